// File: doc/BRIEF.md
# Dual-Modulus Prescaler Controller

This block steers an external prescaler that divides its input either by P+1 or by P, depending on a single control line. The block runs on the prescaler's output pulses. Two down-counters run in step, one loaded with the main count N and one loaded with the swallow count A. Together they make the overall divider reach a ratio of N·P + A.

While the swallow counter still holds a count, the control line stays low and the prescaler divides by P+1. Once that counter has run out, the line goes high and the prescaler divides by P for the rest of the main count. On the final pulse of the main count, the block raises a one-clock end-of-cycle strobe for the phase detector. Both counters then reload.

The programmed values are sampled only on the clock edge that ends a cycle, so a cycle already running always completes with the values it started with. A zero main count is treated as one. A swallow count greater than the effective main count is clamped to it.

Top module: `dmp_ctrl`

## Requirements
- R1: While rst_ni is low, mod_ctrl_o is 1 and cycle_o is 0. The first clock edge after reset is released loads the programmed values and starts a cycle.
- R2: A cycle lasts exactly N_eff clocks, where N_eff = n_val_i, or 1 when n_val_i is 0. cycle_o is 1 in the last clock of each cycle and 0 in every other clock.
- R3: In the clocks of a cycle numbered 0 to N_eff−1, mod_ctrl_o is 0 for clock numbers below A_eff and 1 for all later clocks. This gives A_eff clocks at the P+1 ratio and N_eff−A_eff clocks at the P ratio.
- R4: When a_val_i is 0, mod_ctrl_o stays 1 for the whole cycle.
- R5: A_eff = min(a_val_i, N_eff). With a_val_i ≥ N_eff, mod_ctrl_o stays 0 for the whole cycle.
- R6: n_val_i = 0 gives one-clock cycles, so cycle_o is 1 in every clock.
- R7: n_val_i and a_val_i are sampled only on the clock edge that ends a cycle (or on the first edge after reset). Changes at any other time do not alter the running cycle.
- R8: Once mod_ctrl_o is high inside a cycle, it does not fall before that cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Prescaler output pulse train, used as the clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| n_val_i | input | NW (10) | Programmed main count N |
| a_val_i | input | AW (7) | Programmed swallow count A |
| mod_ctrl_o | output | 1 | Prescaler modulus select: 0 selects P+1, 1 selects P |
| cycle_o | output | 1 | One-clock end-of-cycle strobe |

## Verification
The bench targets the edges of the swallow window:
- A equal to zero. A design with an off-by-one here would emit one spurious low clock.
- A equal to N, and A greater than N. Without clamping, the swallow counter would outlive the main count, and the control line would stay low into the next cycle.
- N equal to zero, which a naive counter would wrap into a cycle of 2^NW clocks.

It also rewrites both programmed values in the middle of a cycle. A design that samples them early would shorten or reshape that cycle instead of holding the change until the boundary. Finally, it asserts reset in the middle of a cycle and checks that the restart reloads cleanly.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  function automatic int wmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic {PH_PRIME = 1'b1, PH_RUN = 1'b0} dmp_phase_e;
endpackage

// File: rtl/dmp_prog.sv
module dmp_prog #(
  parameter int NW = 10,
  parameter int AW = 7
) (
  input  logic [NW-1:0] n_val_i,
  input  logic [AW-1:0] a_val_i,
  output logic [NW-1:0] n_eff_o,
  output logic [AW-1:0] a_eff_o
);
  localparam int MW = dmp_pkg::wmax(NW, AW);

  logic [MW-1:0] n_w, a_w;

  always_comb begin
    n_eff_o = (n_val_i == '0) ? NW'(1) : n_val_i;
    n_w     = MW'(n_eff_o);
    a_w     = MW'(a_val_i);
    // clamp swallow count to main count; when it exceeds, n_eff < 2^AW
    a_eff_o = (a_w > n_w) ? AW'(n_w) : a_val_i;
  end
endmodule

// File: rtl/dmp_n_cnt.sv
module dmp_n_cnt #(
  parameter int NW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [NW-1:0] load_val_i,
  output logic [NW-1:0] cnt_o,
  output logic          last_o
);
  logic [NW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= NW'(1);
    else if (load_i) cnt_q <= load_val_i;
    else             cnt_q <= cnt_q - NW'(1);
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == NW'(1));
endmodule

// File: rtl/dmp_a_cnt.sv
module dmp_a_cnt #(
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  output logic [AW-1:0] cnt_o,
  output logic          done_o
);
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - AW'(1);
  end

  assign cnt_o  = cnt_q;
  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/dmp_ctrl.sv
module dmp_ctrl #(
  parameter int NW = 10,
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NW-1:0] n_val_i,
  input  logic [AW-1:0] a_val_i,
  output logic          mod_ctrl_o,
  output logic          cycle_o
);
  import dmp_pkg::*;

  localparam int MW = wmax(NW, AW);

  dmp_phase_e    phase_q;
  logic [NW-1:0] n_eff, n_cnt;
  logic [AW-1:0] a_eff, a_cnt;
  logic          n_last, a_done, load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_PRIME;
    else         phase_q <= PH_RUN;
  end

  assign load = (phase_q == PH_PRIME) | n_last;

  dmp_prog #(.NW(NW), .AW(AW)) u_prog (
    .n_val_i (n_val_i),
    .a_val_i (a_val_i),
    .n_eff_o (n_eff),
    .a_eff_o (a_eff)
  );

  dmp_n_cnt #(.NW(NW)) u_n_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (n_eff),
    .cnt_o      (n_cnt),
    .last_o     (n_last)
  );

  dmp_a_cnt #(.AW(AW)) u_a_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (a_eff),
    .cnt_o      (a_cnt),
    .done_o     (a_done)
  );

  assign mod_ctrl_o = a_done;
  assign cycle_o    = (phase_q == PH_RUN) & n_last;

  // R8: high modulus holds until end of cycle
  a_r8_mod_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RUN && mod_ctrl_o && !cycle_o) |=> mod_ctrl_o);

  // R7: counter reloads on cycle end with value sampled at that edge
  a_r7_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_o |=> (n_cnt == $past(n_eff)) && (a_cnt == $past(a_eff)));

  // R5: swallow count never exceeds remaining main count
  a_r5_a_within_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RUN) |-> (MW'(a_cnt) <= MW'(n_cnt)));

  // R6: main counter never sits at zero
  a_r6_n_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_cnt != '0);

  // R1: reset state seen on first running clock is a fresh load
  a_r1_first_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PRIME) |=> (n_cnt == $past(n_eff)));
endmodule

// File: tb/dmp_ctrl_tb.sv
module dmp_ctrl_tb;
  localparam int NW = 10;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NW-1:0] n_val = '0;
  logic [AW-1:0] a_val = '0;
  logic          mod_ctrl, cyc;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  dmp_ctrl #(.NW(NW), .AW(AW)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .n_val_i    (n_val),
    .a_val_i    (a_val),
    .mod_ctrl_o (mod_ctrl),
    .cycle_o    (cyc)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // reset, check reset state (R1), release and let the load edge pass
  task automatic do_reset(input int n, input int a);
    @(negedge clk);
    rst_n = 1'b0;
    n_val = NW'(n);
    a_val = AW'(a);
    repeat (2) @(negedge clk);
    chk("R1", "mod in reset", mod_ctrl, 1'b1);
    chk("R1", "cycle in reset", cyc, 1'b0);
    rst_n = 1'b1;
    @(posedge clk);
  endtask

  // check one full cycle; optionally reprogram during its first clock
  task automatic run_cycle(input string req, input int n, input int a,
                           input bit chg, input int nn, input int na);
    int ne, ae;
    ne = (n == 0) ? 1 : n;
    ae = (a > ne) ? ne : a;
    for (int j = 0; j < ne; j++) begin
      @(negedge clk);
      chk(req, "mod", mod_ctrl, (j >= ae) ? 1'b1 : 1'b0);
      chk(req, "cycle", cyc, (j == ne - 1) ? 1'b1 : 1'b0);
      if (chg && j == 0) begin
        n_val = NW'(nn);
        a_val = AW'(na);
      end
      @(posedge clk);
    end
  endtask

  task automatic t_basic();
    do_reset(5, 2);
    run_cycle("R3", 5, 2, 1'b0, 0, 0);
    run_cycle("R2", 5, 2, 1'b0, 0, 0);
  endtask

  task automatic t_a_zero();
    do_reset(4, 0);
    run_cycle("R4", 4, 0, 1'b0, 0, 0);
    run_cycle("R4", 4, 0, 1'b0, 0, 0);
  endtask

  task automatic t_a_eq_over();
    do_reset(3, 3);
    run_cycle("R5", 3, 3, 1'b1, 3, 6);
    run_cycle("R5", 3, 6, 1'b0, 0, 0);
  endtask

  task automatic t_n_zero();
    do_reset(0, 0);
    run_cycle("R6", 0, 0, 1'b0, 0, 0);
    run_cycle("R6", 0, 0, 1'b1, 0, 3);
    run_cycle("R6", 0, 3, 1'b0, 0, 0);
    run_cycle("R6", 0, 3, 1'b0, 0, 0);
  endtask

  task automatic t_boundary();
    do_reset(6, 2);
    run_cycle("R7", 6, 2, 1'b1, 3, 1);
    run_cycle("R7", 3, 1, 1'b1, 7, 5);
    run_cycle("R7", 7, 5, 1'b0, 0, 0);
  endtask

  task automatic t_reset_mid();
    do_reset(8, 4);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "mod async reset", mod_ctrl, 1'b1);
    chk("R1", "cycle async reset", cyc, 1'b0);
    do_reset(4, 1);
    run_cycle("R1", 4, 1, 1'b0, 0, 0);
  endtask

  task automatic t_wide();
    do_reset(200, 127);
    run_cycle("R3", 200, 127, 1'b0, 0, 0);
    run_cycle("R8", 200, 127, 1'b1, 1023, 0);
    run_cycle("R4", 1023, 0, 1'b0, 0, 0);
  endtask

  initial begin
    t_basic();
    t_a_zero();
    t_a_eq_over();
    t_n_zero();
    t_boundary();
    t_reset_mid();
    t_wide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule